// File: doc/BRIEF.md
# Page Access Abort Checker

This block judges every memory access of a segmented memory management unit against the descriptor of the page it falls in. Each access presents a 16-bit virtual address, the processor mode that performs it (kernel, supervisor or user), an instruction/data space select, a write flag, and the descriptor already chosen for that page. The descriptor holds a 7-bit length in 64-byte clicks, an expansion direction and a 3-bit access-control code. The block reports, one cycle later, whether the access is refused because the page is not resident, because the offset lies outside the page's length, or because it writes a read-only page.

The first refused access also loads a 16-bit status word. That word records the abort reasons, the mode, the space and the page number of the failing access. It then stays frozen, so later aborts cannot hide the first one. It frees again only when the clear input wipes the abort bits. Address relocation and trap vectoring are left to neighbouring logic.

Top module: `pgabort_unit`

## Requirements
- R1: After synchronous reset the status word reads 0x0000 and the abort outputs are low.
- R2: The flag outputs and `abort_o` are registered. They show the result of an access one cycle after `acc_valid` is sampled high, `abort_o` is the OR of the three flags, and all of them are low in the cycle after an edge with `acc_valid` low.
- R3: Any access-control code other than 2 and 6 (0 included) marks the page non-resident. Every access to such a page raises the non-resident flag only, and suppresses the length and read-only flags.
- R4: Code 2 makes the page read-only. A write raises the read-only flag and a read does not.
- R5: Code 6 permits both reads and writes, so neither the non-resident nor the read-only flag is raised.
- R6: The click index is address bits 12:6. For an upward page (direction 0) the length flag rises when the click index is greater than the length field, so length 0 allows offsets 0 to 63 only.
- R7: For a downward page (direction 1) the length flag rises when the click index is less than the length field, so length 127 allows only the top click.
- R8: On a resident page a length violation and a read-only violation are reported together when both apply.
- R9: When no abort bit is set, an aborting access loads the status word. Bit 15 holds non-resident, bit 14 length and bit 13 read-only. Bits 6:5 hold the access's own mode (00 kernel, 01 supervisor, 11 user), bit 4 the D-space select and bits 3:1 the page number from address bits 15:13.
- R10: While any abort bit is set, status bits 15:1 hold their values and further aborting accesses change nothing.
- R11: A high `stat_clr` zeroes bits 15:13 on the next edge and wins over a capture at that edge. The mode, space and page fields keep their values.
- R12: Status bit 0 follows `mmu_en` one cycle later. While `mmu_en` is low no access aborts.
- R13: Status bit 7 follows `instr_done` one cycle later while no abort bit is set, and holds its value while the status word is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmu_en | input | 1 | Translation enable; aborts only when high |
| instr_done | input | 1 | Instruction-complete indication mirrored in status bit 7 |
| stat_clr | input | 1 | Clears the abort bits of the status word |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_vaddr | input | 16 | Virtual address of the access |
| acc_mode | input | 2 | Mode performing the access: 00 kernel, 01 supervisor, 11 user |
| acc_dspace | input | 1 | 1 selects D space, 0 I space |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| desc_len | input | 7 | Page length in 64-byte clicks |
| desc_down | input | 1 | Expansion direction, 1 for downward |
| desc_acf | input | 3 | Access-control code |
| abort_o | output | 1 | Registered: the access was refused |
| flag_nr_o | output | 1 | Registered: non-resident page |
| flag_len_o | output | 1 | Registered: length violation |
| flag_ro_o | output | 1 | Registered: write to read-only page |
| status_o | output | 16 | Abort status word |

## Verification
The assertions take for granted that `acc_mode` never carries the unused code 10 and that the descriptor inputs belong to the page addressed by `acc_vaddr`. They also assume `stat_clr` is driven by software between accesses, not as part of an access. The stimulus draws modes only from the three legal codes, and it supplies the descriptor fields directly, so no page table is needed. In the main sweep the bench clears the abort bits after every refused access, so each access meets an unfrozen status word. The frozen, clear-versus-capture and enable orderings are driven in separate directed sequences.

// File: rtl/pga_pkg.sv
package pga_pkg;

  typedef enum logic [1:0] {
    MODE_KER = 2'b00,
    MODE_SUP = 2'b01,
    MODE_USR = 2'b11
  } mode_e;

  localparam logic [2:0] ACF_RDONLY = 3'd2;
  localparam logic [2:0] ACF_RDWR   = 3'd6;

  localparam int STAT_W      = 16;
  localparam int ST_NR_BIT   = 15;
  localparam int ST_LEN_BIT  = 14;
  localparam int ST_RO_BIT   = 13;
  localparam int ST_DONE_BIT = 7;

  typedef struct packed {
    logic nr;
    logic len;
    logic ro;
  } flags_t;

endpackage

// File: rtl/pga_acf_decode.sv
module pga_acf_decode
  import pga_pkg::*;
(
  input  logic [2:0] acf,
  input  logic       is_write,
  output logic       nonres,
  output logic       ro_viol
);
  always_comb begin
    nonres  = 1'b1;
    ro_viol = 1'b0;
    unique case (acf)
      ACF_RDONLY: begin
        nonres  = 1'b0;
        ro_viol = is_write;
      end
      ACF_RDWR: nonres = 1'b0;
      default:  nonres = 1'b1;
    endcase
  end
endmodule

// File: rtl/pga_len_check.sv
module pga_len_check #(
  parameter int CLICK_W = 7
) (
  input  logic [CLICK_W-1:0] click,
  input  logic [CLICK_W-1:0] limit,
  input  logic               grows_down,
  output logic               len_viol
);
  logic above_lim;
  logic below_lim;

  assign above_lim = (click > limit);
  assign below_lim = (click < limit);
  assign len_viol  = grows_down ? below_lim : above_lim;
endmodule

// File: rtl/pga_status_reg.sv
module pga_status_reg
  import pga_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_in,
  input  logic              done_in,
  input  logic              clr,
  input  logic              hit,
  input  flags_t            hit_flags,
  input  logic [1:0]        hit_mode,
  input  logic              hit_dspace,
  input  logic [PAGE_W-1:0] hit_page,
  output logic [STAT_W-1:0] stat
);
  localparam int PAD_W = ST_RO_BIT - ST_DONE_BIT - 1;

  flags_t            abt_q;
  logic [1:0]        mode_q;
  logic              ds_q;
  logic [PAGE_W-1:0] page_q;
  logic              en_q;
  logic              done_q;
  logic              frozen;

  assign frozen = abt_q.nr | abt_q.len | abt_q.ro;

  always_ff @(posedge clk) begin
    if (rst) begin
      abt_q  <= '0;
      mode_q <= '0;
      ds_q   <= 1'b0;
      page_q <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      en_q <= en_in;
      if (!frozen) done_q <= done_in;
      if (clr) begin
        abt_q <= '0;
      end else if (hit && !frozen) begin
        abt_q  <= hit_flags;
        mode_q <= hit_mode;
        ds_q   <= hit_dspace;
        page_q <= hit_page;
      end
    end
  end

  assign stat = {abt_q.nr, abt_q.len, abt_q.ro, {PAD_W{1'b0}},
                 done_q, mode_q, ds_q, page_q, en_q};
endmodule

// File: rtl/pgabort_unit.sv
module pgabort_unit
  import pga_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int CLICK_LSB = 6,
  parameter int CLICK_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mmu_en,
  input  logic               instr_done,
  input  logic               stat_clr,
  input  logic               acc_valid,
  input  logic [VA_W-1:0]    acc_vaddr,
  input  logic [1:0]         acc_mode,
  input  logic               acc_dspace,
  input  logic               acc_write,
  input  logic [CLICK_W-1:0] desc_len,
  input  logic               desc_down,
  input  logic [2:0]         desc_acf,
  output logic               abort_o,
  output logic               flag_nr_o,
  output logic               flag_len_o,
  output logic               flag_ro_o,
  output logic [STAT_W-1:0]  status_o
);
  localparam int PAGE_LSB = CLICK_LSB + CLICK_W;
  localparam int PAGE_W   = VA_W - PAGE_LSB;

  logic [PAGE_W-1:0]  page_idx;
  logic [CLICK_W-1:0] click_idx;
  logic               unused_offset;

  assign page_idx      = acc_vaddr[VA_W-1:PAGE_LSB];
  assign click_idx     = acc_vaddr[PAGE_LSB-1:CLICK_LSB];
  assign unused_offset = &{1'b0, acc_vaddr[CLICK_LSB-1:0]};

  logic nonres, ro_raw, len_raw;

  pga_acf_decode acf_i (
    .acf      (desc_acf),
    .is_write (acc_write),
    .nonres   (nonres),
    .ro_viol  (ro_raw)
  );

  pga_len_check #(.CLICK_W(CLICK_W)) len_i (
    .click      (click_idx),
    .limit      (desc_len),
    .grows_down (desc_down),
    .len_viol   (len_raw)
  );

  flags_t now_flags;
  logic   now_abort;
  logic   armed;

  assign armed         = acc_valid && mmu_en;
  assign now_flags.nr  = armed && nonres;
  assign now_flags.len = armed && !nonres && len_raw;
  assign now_flags.ro  = armed && !nonres && ro_raw;
  assign now_abort     = now_flags.nr | now_flags.len | now_flags.ro;

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_o    <= 1'b0;
      flag_nr_o  <= 1'b0;
      flag_len_o <= 1'b0;
      flag_ro_o  <= 1'b0;
    end else begin
      abort_o    <= now_abort;
      flag_nr_o  <= now_flags.nr;
      flag_len_o <= now_flags.len;
      flag_ro_o  <= now_flags.ro;
    end
  end

  pga_status_reg #(.PAGE_W(PAGE_W)) stat_i (
    .clk        (clk),
    .rst        (rst),
    .en_in      (mmu_en),
    .done_in    (instr_done),
    .clr        (stat_clr),
    .hit        (now_abort),
    .hit_flags  (now_flags),
    .hit_mode   (acc_mode),
    .hit_dspace (acc_dspace),
    .hit_page   (page_idx),
    .stat       (status_o)
  );
endmodule

// File: rtl/pga_checker.sv
module pga_checker (
  input logic        clk,
  input logic        rst,
  input logic        mmu_en,
  input logic        stat_clr,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [2:0]  desc_acf,
  input logic        abort_o,
  input logic        flag_nr_o,
  input logic        flag_len_o,
  input logic        flag_ro_o,
  input logic [15:0] status_o
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !abort_o);

  p_any_flag_r2: assert property (@(posedge clk) disable iff (rst)
    abort_o == (flag_nr_o | flag_len_o | flag_ro_o));

  p_nr_alone_r3: assert property (@(posedge clk) disable iff (rst)
    flag_nr_o |-> (!flag_len_o && !flag_ro_o));

  p_read_no_ro_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> !flag_ro_o);

  p_rw_page_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && desc_acf == 3'd6) |=> (!flag_nr_o && !flag_ro_o));

  p_capture_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(|status_o[15:13]) |-> abort_o);

  p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    ((|status_o[15:13]) && !stat_clr) |=> $stable(status_o[15:1]));

  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    stat_clr |=> (status_o[15:13] == 3'b000));

  p_disabled_r12: assert property (@(posedge clk) disable iff (rst)
    !mmu_en |=> !abort_o);

  p_enbit_r12: assert property (@(posedge clk) disable iff (rst)
    mmu_en |=> status_o[0]);
endmodule

bind pgabort_unit pga_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .mmu_en     (mmu_en),
  .stat_clr   (stat_clr),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .desc_acf   (desc_acf),
  .abort_o    (abort_o),
  .flag_nr_o  (flag_nr_o),
  .flag_len_o (flag_len_o),
  .flag_ro_o  (flag_ro_o),
  .status_o   (status_o)
);

// File: tb/pgabort_unit_tb_top.sv
`timescale 1ns/1ps
module pgabort_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mmu_en = 1'b0;
  logic        instr_done = 1'b0;
  logic        stat_clr = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_vaddr = '0;
  logic [1:0]  acc_mode = '0;
  logic        acc_dspace = 1'b0;
  logic        acc_write = 1'b0;
  logic [6:0]  desc_len = '0;
  logic        desc_down = 1'b0;
  logic [2:0]  desc_acf = '0;
  logic        abort_o, flag_nr_o, flag_len_o, flag_ro_o;
  logic [15:0] status_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pgabort_unit dut_i (
    .clk(clk), .rst(rst), .mmu_en(mmu_en), .instr_done(instr_done),
    .stat_clr(stat_clr), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
    .acc_mode(acc_mode), .acc_dspace(acc_dspace), .acc_write(acc_write),
    .desc_len(desc_len), .desc_down(desc_down), .desc_acf(desc_acf),
    .abort_o(abort_o), .flag_nr_o(flag_nr_o), .flag_len_o(flag_len_o),
    .flag_ro_o(flag_ro_o), .status_o(status_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic [1:0] m, input logic ds, input logic wr,
                        input logic [15:0] va, input logic [6:0] ln,
                        input logic dn, input logic [2:0] af);
    acc_valid  = 1'b1;
    acc_mode   = m;
    acc_dspace = ds;
    acc_write  = wr;
    acc_vaddr  = va;
    desc_len   = ln;
    desc_down  = dn;
    desc_acf   = af;
    step();
    acc_valid  = 1'b0;
  endtask

  task automatic clear_abt();
    stat_clr = 1'b1;
    step();
    stat_clr = 1'b0;
  endtask

  function automatic logic [15:0] mk_stat(input logic [2:0] f, input logic dn_bit,
      input logic [1:0] m, input logic ds, input logic [2:0] pg, input logic en);
    return {f, 5'b0, dn_bit, m, ds, pg, en};
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] modes [3];
    logic [6:0] lens [5];
    modes[0] = 2'b00; modes[1] = 2'b01; modes[2] = 2'b11;
    lens[0] = 7'd0; lens[1] = 7'd1; lens[2] = 7'd63; lens[3] = 7'd126; lens[4] = 7'd127;

    @(negedge clk);
    step(); step();
    rst = 1'b0;
    // R1 reset state
    check(status_o == 16'h0000, "R1", status_o, 16'h0000);
    check({abort_o, flag_nr_o, flag_len_o, flag_ro_o} == 4'b0, "R1",
          {12'b0, abort_o, flag_nr_o, flag_len_o, flag_ro_o}, 16'h0);

    // R12 disabled: non-resident page does not abort
    access(2'b11, 1'b0, 1'b1, 16'h2000, 7'd0, 1'b0, 3'd0);
    check(!abort_o, "R12", {15'b0, abort_o}, 16'h0);
    check(status_o == 16'h0000, "R12", status_o, 16'h0000);
    mmu_en = 1'b1;
    step();
    check(status_o[0] == 1'b1, "R12", status_o, 16'h0001);
    // R2 quiet cycle after no access
    check(!abort_o, "R2", {15'b0, abort_o}, 16'h0);

    // R13 done bit follows while not frozen
    instr_done = 1'b1;
    step();
    check(status_o[7] == 1'b1, "R13", status_o, 16'h0081);

    // R9 / R10 first abort captured, second ignored
    access(2'b11, 1'b1, 1'b0, 16'hA040, 7'd0, 1'b0, 3'd0);
    check({abort_o, flag_nr_o} == 2'b11, "R3", {14'b0, abort_o, flag_nr_o}, 16'h3);
    check(status_o == mk_stat(3'b100, 1'b1, 2'b11, 1'b1, 3'd5, 1'b1), "R9",
          status_o, mk_stat(3'b100, 1'b1, 2'b11, 1'b1, 3'd5, 1'b1));
    instr_done = 1'b0;
    access(2'b00, 1'b0, 1'b1, 16'h4000, 7'd0, 1'b0, 3'd2);
    check(flag_ro_o == 1'b1, "R4", {15'b0, flag_ro_o}, 16'h1);
    check(status_o == mk_stat(3'b100, 1'b1, 2'b11, 1'b1, 3'd5, 1'b1), "R10",
          status_o, mk_stat(3'b100, 1'b1, 2'b11, 1'b1, 3'd5, 1'b1));
    check(status_o[7] == 1'b1, "R13", status_o, 16'h0080);

    // R11 clear wins over simultaneous capture; fields retained
    stat_clr = 1'b1;
    access(2'b01, 1'b0, 1'b0, 16'h6000, 7'd0, 1'b0, 3'd0);
    stat_clr = 1'b0;
    check(status_o == mk_stat(3'b000, 1'b1, 2'b11, 1'b1, 3'd5, 1'b1), "R11",
          status_o, mk_stat(3'b000, 1'b1, 2'b11, 1'b1, 3'd5, 1'b1));
    step();
    check(status_o[7] == 1'b0, "R13", status_o, 16'h0000);

    // R8 both length and read-only on a resident page
    access(2'b01, 1'b0, 1'b1, 16'h2FC0, 7'd0, 1'b0, 3'd2);
    check({flag_nr_o, flag_len_o, flag_ro_o} == 3'b011, "R8",
          {13'b0, flag_nr_o, flag_len_o, flag_ro_o}, 16'h3);
    check(status_o == mk_stat(3'b011, 1'b0, 2'b01, 1'b0, 3'd1, 1'b1), "R9",
          status_o, mk_stat(3'b011, 1'b0, 2'b01, 1'b0, 3'd1, 1'b1));
    clear_abt();

    // R5 read/write page accepts a write in range
    access(2'b00, 1'b1, 1'b1, 16'h3FFE, 7'd127, 1'b1, 3'd6);
    check(!abort_o, "R5", {15'b0, abort_o}, 16'h0);

    // Sweep: R3 R4 R6 R7 R9 R11
    for (int af = 0; af < 8; af++)
      for (int dn = 0; dn < 2; dn++)
        for (int wr = 0; wr < 2; wr++)
          for (int li = 0; li < 5; li++)
            for (int c = 0; c < 128; c++) begin
              logic [2:0]  pg;
              logic [15:0] va;
              logic [1:0]  m;
              logic        ds, e_nr, e_len, e_ro;
              logic [6:0]  ln;
              string       tag;
              pg = 3'((c + af) % 8);
              ln = lens[li];
              va = {pg, 7'(c), 6'(c)};
              m  = modes[(c + li) % 3];
              ds = 1'((c >> 1) & 1);
              e_nr  = !(af == 2 || af == 6);
              e_len = !e_nr && (dn == 1 ? (7'(c) < ln) : (7'(c) > ln));
              e_ro  = !e_nr && af == 2 && wr == 1;
              tag = e_nr ? "R3" : (af == 2 && wr == 1) ? "R4" : (dn == 1) ? "R7" : "R6";
              access(m, ds, 1'(wr), va, ln, 1'(dn), 3'(af));
              check({abort_o, flag_nr_o, flag_len_o, flag_ro_o} ==
                    {e_nr | e_len | e_ro, e_nr, e_len, e_ro}, tag,
                    {12'b0, abort_o, flag_nr_o, flag_len_o, flag_ro_o},
                    {12'b0, e_nr | e_len | e_ro, e_nr, e_len, e_ro});
              if (e_nr | e_len | e_ro) begin
                check(status_o == mk_stat({e_nr, e_len, e_ro}, 1'b0, m, ds, pg, 1'b1),
                      "R9", status_o,
                      mk_stat({e_nr, e_len, e_ro}, 1'b0, m, ds, pg, 1'b1));
                clear_abt();
                check(status_o[15:13] == 3'b000, "R11", status_o,
                      {3'b000, status_o[12:0]});
              end
            end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule